// File: doc/BRIEF.md
# Zero-Vector-Free Current-Source Inverter Gate Modulator

This block drives the six switches of a three-phase current-source bridge with a space-vector pattern that never applies a zero vector. In every carrier period it applies only the two active current vectors on either side of the reference. The first vector is applied at the start of the period and the second fills the rest. The split between them follows sin(60° − θ) against sin θ. That ratio is normalised so that the two dwells together always fill the whole period, whatever the angle. Within a sector one device conducts for the entire sector. Only the two devices on the opposite side of the bridge commutate, so each switch does PWM in two of the six sectors.

An upstream angle generator supplies a sector number, an angle inside the sector and a carrier length in clock cycles. The block samples these only when a carrier period starts, so the pattern never changes part way through a period. When the block is disabled, or the sector code is not valid, it holds the upper and lower switches of leg A on together. This gives the dc-link current a bypass path. A final guard blanks all gates and raises a fault flag if a pattern ever turns on two switches on the same side of the bridge.

Top module: `csi_zvf_modulator`

## Requirements
- R1: Vector k conducts (upper leg, lower leg) as k0=(A,B), k1=(A,C), k2=(B,C), k3=(B,A), k4=(C,A), k5=(C,B). Gate bits are [0]=upper A, [1]=upper B, [2]=upper C, [3]=lower A, [4]=lower B, [5]=lower C. In sector s (0..5) each period applies vector s first and then vector (s+1) mod 6, and no other pattern.
- R2: Whenever the fault flag is low, exactly one upper gate and exactly one lower gate are on.
- R3: The first vector lasts round(P·sin(60°−θ)/(sin(60°−θ)+sin θ)) cycles, within ±1, where θ = angle·60°/256 and P is the period. The second vector lasts the remaining P minus that count.
- R4: In every valid sector exactly one gate stays on for the whole period and exactly two gates change state.
- R5: Sector, angle and period are sampled only when a carrier period starts. A change in the middle of a period first shows in the next period.
- R6: A carrier period lasts exactly `period` cycles. A period value of 0 or 1 is treated as 2.
- R7: Out of reset, and from the clock edge at which enable is seen low, the gates hold the bypass pattern 6'b001001 (upper A and lower A).
- R8: A sector code of 6 or 7 gives the bypass pattern for the whole period.
- R9: A switch commutates only in the two sectors next to its hold sector. Upper A commutates only in sectors 1 and 5.
- R10: The fault flag stays low for every legal pattern. When it is high, all gates are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Modulator enable; low selects the bypass pattern |
| sector | input | 3 | Sector index 0..5; 6 and 7 are invalid |
| angle | input | ANGLE_W | Angle within the sector, full scale is 60° |
| period | input | PER_W | Carrier period in clock cycles |
| gate | output | 6 | Switch gates, upper A/B/C in bits 0..2, lower A/B/C in bits 3..5 |
| fault | output | 1 | Same-side conflict detected; gates blanked |

## Verification
When enable is seen high at an edge, the gates still show bypass after that edge. Sample 0 of the first period appears after the following edge. Each later period starts exactly `period` edges after the previous one. Inputs changed after the first edge of a period appear only in the samples of the next period. A low enable gives bypass after the very next edge. Every check is taken at the falling edge after the edge that produced the value, so whole periods are captured sample by sample and counted against the expected dwell and order.

// File: rtl/csi_zvf_pkg.sv
package csi_zvf_pkg;

   localparam int GATE_W      = 6;
   localparam int NUM_SECTORS = 6;

   // upper A and lower A together: dc-link current bypass through leg A
   localparam logic [GATE_W-1:0] GATES_BYPASS = 6'b001_001;

   typedef struct packed {
      logic [1:0] hi;   // conducting upper leg: 0=A 1=B 2=C
      logic [1:0] lo;   // conducting lower leg
   } leg_pair_t;

   // fixed six-entry active-vector table (R1)
   function automatic leg_pair_t vector_pair(input logic [2:0] vec);
      leg_pair_t p;
      case (vec)
         3'd0:    p = '{hi: 2'd0, lo: 2'd1};
         3'd1:    p = '{hi: 2'd0, lo: 2'd2};
         3'd2:    p = '{hi: 2'd1, lo: 2'd2};
         3'd3:    p = '{hi: 2'd1, lo: 2'd0};
         3'd4:    p = '{hi: 2'd2, lo: 2'd0};
         3'd5:    p = '{hi: 2'd2, lo: 2'd1};
         default: p = '{hi: 2'd0, lo: 2'd0};
      endcase
      return p;
   endfunction

   function automatic logic [GATE_W-1:0] pair_to_gates(input leg_pair_t p);
      logic [GATE_W-1:0] up;
      logic [GATE_W-1:0] dn;
      up = GATE_W'(6'b000_001 << p.hi);
      dn = GATE_W'(6'b001_000 << p.lo);
      return up | dn;
   endfunction

   function automatic logic [2:0] next_sector(input logic [2:0] s);
      return (s == 3'(NUM_SECTORS - 1)) ? 3'd0 : s + 3'd1;
   endfunction

endpackage

// File: rtl/csi_dwell_rom.sv
module csi_dwell_rom #(
   parameter int ANGLE_W       = 8,
   parameter int PER_W         = 16,
   parameter int DUTY_W        = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic [ANGLE_W-1:0] angle,
   input  logic [PER_W-1:0]   period,
   output logic [PER_W:0]     first_len
);

   localparam int  DEPTH  = 1 << ANGLE_W;
   localparam int  DW1    = DUTY_W + 1;
   localparam int  PROD_W = DW1 + PER_W;
   localparam real PI_R   = 3.14159265358979;

   function automatic real sin_series(input real x);
      real term;
      real acc;
      term = x;
      acc  = x;
      for (int k = 1; k < 9; k++) begin
         term = -term * x * x / ((2.0 * k) * (2.0 * k + 1.0));
         acc  = acc + term;
      end
      return acc;
   endfunction

   // normalised first-vector share, sin(60-th)/(sin(60-th)+sin th), in Q.DUTY_W
   function automatic int duty_code(input int idx);
      real th;
      real s1;
      real s2;
      th = (PI_R / 3.0) * idx / (2.0 ** ANGLE_W);
      s1 = sin_series(PI_R / 3.0 - th);
      s2 = sin_series(th);
      return $rtoi(s1 / (s1 + s2) * (2.0 ** DUTY_W) + 0.5);
   endfunction

   logic [DW1-1:0] ratio_rom [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      localparam logic [DW1-1:0] ENTRY = DW1'(duty_code(i));
      assign ratio_rom[i] = ENTRY;
   end

   logic [DW1-1:0]    ratio;
   logic [PROD_W-1:0] prod;

   assign ratio = ratio_rom[angle];
   assign prod  = PROD_W'(ratio) * PROD_W'(period);

   // R3: dwell of the first vector scaled to the carrier period
   if (ROUND_NEAREST) begin : g_round
      assign first_len = (PER_W + 1)'((prod + PROD_W'(1 << (DUTY_W - 1))) >> DUTY_W);
   end else begin : g_trunc
      assign first_len = (PER_W + 1)'(prod >> DUTY_W);
   end

endmodule

// File: rtl/csi_carrier.sv
module csi_carrier #(
   parameter int ANGLE_W = 8,
   parameter int PER_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [2:0]         sector_i,
   input  logic [ANGLE_W-1:0] angle_i,
   input  logic [PER_W-1:0]   period_i,
   output logic               run,
   output logic               load,
   output logic [PER_W-1:0]   cnt,
   output logic [2:0]         sec_q,
   output logic [ANGLE_W-1:0] ang_q,
   output logic [PER_W-1:0]   per_q
);

   localparam logic [PER_W-1:0] PER_MIN = PER_W'(2);

   logic [PER_W-1:0] per_clamped;
   logic             run_q;
   logic [PER_W-1:0] cnt_q;

   // R6: shortest legal carrier is two cycles
   assign per_clamped = (period_i < PER_MIN) ? PER_MIN : period_i;

   // R5: new operating point only at a period start
   assign load = en && (!run_q || (cnt_q == per_q - PER_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         sec_q <= '0;
         ang_q <= '0;
         per_q <= PER_MIN;
      end else if (!en) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load) begin
         run_q <= 1'b1;
         cnt_q <= '0;
         sec_q <= sector_i;
         ang_q <= angle_i;
         per_q <= per_clamped;
      end else begin
         cnt_q <= cnt_q + PER_W'(1);
      end
   end

   assign run = run_q;
   assign cnt = cnt_q;

endmodule

// File: rtl/csi_vector_map.sv
module csi_vector_map
   import csi_zvf_pkg::*;
#(
   parameter int PER_W = 16
) (
   input  logic              en,
   input  logic              run,
   input  logic [2:0]        sec,
   input  logic [PER_W-1:0]  cnt,
   input  logic [PER_W:0]    first_len,
   output logic [GATE_W-1:0] gates_raw
);

   logic       in_first;
   logic [2:0] vec;

   assign in_first = {1'b0, cnt} < first_len;
   // R1: first the vector at the sector start, then the next one
   assign vec      = in_first ? sec : next_sector(sec);

   always_comb begin
      if (!en || !run) begin
         gates_raw = GATES_BYPASS;                          // R7
      end else if (sec >= 3'(NUM_SECTORS)) begin
         gates_raw = GATES_BYPASS;                          // R8
      end else begin
         gates_raw = pair_to_gates(vector_pair(vec));
      end
   end

endmodule

// File: rtl/csi_gate_guard.sv
module csi_gate_guard
   import csi_zvf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GATE_W-1:0] gates_raw,
   output logic [GATE_W-1:0] gate,
   output logic              fault
);

   logic conflict;

   // R10: two devices of one side on together is never allowed out
   assign conflict = ($countones(gates_raw[2:0]) > 1) ||
                     ($countones(gates_raw[5:3]) > 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate  <= GATES_BYPASS;
         fault <= 1'b0;
      end else if (conflict) begin
         gate  <= '0;
         fault <= 1'b1;
      end else begin
         gate  <= gates_raw;
         fault <= 1'b0;
      end
   end

endmodule

// File: rtl/csi_zvf_modulator.sv
module csi_zvf_modulator
   import csi_zvf_pkg::*;
#(
   parameter int ANGLE_W       = 8,
   parameter int PER_W         = 16,
   parameter int DUTY_W        = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [2:0]         sector,
   input  logic [ANGLE_W-1:0] angle,
   input  logic [PER_W-1:0]   period,
   output logic [5:0]         gate,
   output logic               fault
);

   if (ANGLE_W < 4 || ANGLE_W > 10) begin : g_bad_angle_w
      $error("ANGLE_W must lie in 4..10");
   end
   if (PER_W < 2 || PER_W > 24) begin : g_bad_per_w
      $error("PER_W must lie in 2..24");
   end
   if (DUTY_W < 8 || DUTY_W > 24) begin : g_bad_duty_w
      $error("DUTY_W must lie in 8..24");
   end

   logic               c_run;
   logic               c_load;
   logic [PER_W-1:0]   c_cnt;
   logic [2:0]         c_sec;
   logic [ANGLE_W-1:0] c_ang;
   logic [PER_W-1:0]   c_per;
   logic [PER_W:0]     first_len;
   logic [GATE_W-1:0]  gates_raw;

   csi_carrier #(
      .ANGLE_W (ANGLE_W),
      .PER_W   (PER_W)
   ) u_carrier (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .sector_i (sector),
      .angle_i  (angle),
      .period_i (period),
      .run      (c_run),
      .load     (c_load),
      .cnt      (c_cnt),
      .sec_q    (c_sec),
      .ang_q    (c_ang),
      .per_q    (c_per)
   );

   csi_dwell_rom #(
      .ANGLE_W       (ANGLE_W),
      .PER_W         (PER_W),
      .DUTY_W        (DUTY_W),
      .ROUND_NEAREST (ROUND_NEAREST)
   ) u_dwell (
      .angle     (c_ang),
      .period    (c_per),
      .first_len (first_len)
   );

   csi_vector_map #(
      .PER_W (PER_W)
   ) u_map (
      .en        (en),
      .run       (c_run),
      .sec       (c_sec),
      .cnt       (c_cnt),
      .first_len (first_len),
      .gates_raw (gates_raw)
   );

   csi_gate_guard u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .gates_raw (gates_raw),
      .gate      (gate),
      .fault     (fault)
   );

endmodule

// File: rtl/csi_zvf_modulator_chk.sv
module csi_zvf_modulator_chk #(
   parameter int ANGLE_W = 8,
   parameter int PER_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic [5:0]         gate,
   input logic               fault,
   input logic               load,
   input logic [PER_W-1:0]   cnt,
   input logic [PER_W-1:0]   per,
   input logic [2:0]         sec,
   input logic [ANGLE_W-1:0] ang
);

   a_r2_one_per_side: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> ($countones(gate[2:0]) == 1 && $countones(gate[5:3]) == 1));

   a_r7_bypass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (gate == 6'b001_001));

   a_r10_fault_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (gate == 6'b000_000));

   a_r5_hold_between_starts: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(sec) && $stable(ang) && $stable(per)));

   a_r6_count_below_period: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < per);

endmodule

bind csi_zvf_modulator csi_zvf_modulator_chk #(
   .ANGLE_W (ANGLE_W),
   .PER_W   (PER_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (en),
   .gate  (gate),
   .fault (fault),
   .load  (c_load),
   .cnt   (c_cnt),
   .per   (c_per),
   .sec   (c_sec),
   .ang   (c_ang)
);

// File: tb/test_csi_zvf_modulator.sv
module test_csi_zvf_modulator;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [5:0] BYP = 6'b001_001;
   localparam real PI_R = 3.14159265358979;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] sector = '0;
   logic [7:0] angle = '0;
   logic [15:0] period = 16'd10;
   logic [5:0] gate;
   logic       fault;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [5:0] smp [0:2047];
   logic       fsm [0:2047];

   always #4 clk = ~clk;

   csi_zvf_modulator i_csi_zvf_modulator (
      .clk(clk), .rst_n(rst_n), .en(en), .sector(sector),
      .angle(angle), .period(period), .gate(gate), .fault(fault)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // bench's own vector encoding (R1): upper = k/2, lower = ((k+1)/2 + 1) mod 3
   function automatic logic [5:0] exp_gates(input int k);
      int up;
      int dn;
      up = k / 2;
      dn = (((k + 1) / 2) + 1) % 3;
      return 6'((1 << up) | (8 << dn));
   endfunction

   function automatic int exp_first(input int a, input int p);
      real th;
      real d;
      th = (PI_R / 3.0) * a / 256.0;
      d  = $sin(PI_R / 3.0 - th) / ($sin(PI_R / 3.0 - th) + $sin(th));
      return $rtoi(d * p + 0.5);
   endfunction

   task automatic start_run(input int s, input int a, input int p);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      sector = 3'(s);
      angle  = 8'(a);
      period = 16'(p);
      en     = 1'b1;
      @(posedge clk);
   endtask

   task automatic capture(input int n, input int chg_at, input int s2, input int a2, input int p2);
      for (int j = 0; j < n; j++) begin
         @(posedge clk);
         @(negedge clk);
         smp[j] = gate;
         fsm[j] = fault;
         if (j == chg_at) begin
            sector = 3'(s2);
            angle  = 8'(a2);
            period = 16'(p2);
         end
      end
   endtask

   task automatic t_reset;
      check(gate == BYP, "R7 reset gates bypass", gate, BYP);
      check(fault == 1'b0, "R10 reset fault low", fault, 0);
   endtask

   task automatic t_dwell(input int s, input int a, input int p);
      int n1 = 0;
      int n2 = 0;
      int bad_side = 0;
      int any_fault = 0;
      int e1;
      logic [5:0] g1;
      logic [5:0] g2;
      g1 = exp_gates(s);
      g2 = exp_gates((s + 1) % 6);
      e1 = exp_first(a, p);
      start_run(s, a, p);
      capture(p, -1, 0, 0, 0);
      for (int j = 0; j < p; j++) begin
         if (smp[j] == g1) n1++;
         else if (smp[j] == g2) n2++;
         if ($countones(smp[j][2:0]) != 1 || $countones(smp[j][5:3]) != 1) bad_side++;
         if (fsm[j]) any_fault++;
      end
      check(n1 >= e1 - 1 && n1 <= e1 + 1,
            $sformatf("R3 first dwell s%0d a%0d p%0d", s, a, p), n1, e1);
      check(n1 + n2 == p, $sformatf("R1 only adjacent vectors s%0d", s), n1 + n2, p);
      check(e1 == 0 || smp[0] == g1, $sformatf("R1 first vector leads s%0d", s), smp[0], g1);
      check(bad_side == 0, $sformatf("R2 one per side s%0d", s), bad_side, 0);
      check(any_fault == 0, $sformatf("R10 no fault s%0d", s), any_fault, 0);
   endtask

   task automatic t_sector_sweep;
      for (int s = 0; s < 6; s++) begin
         logic [5:0] or_all;
         logic [5:0] and_all;
         logic [5:0] tog;
         logic [5:0] etog;
         start_run(s, 128, 20);
         capture(20, -1, 0, 0, 0);
         or_all  = '0;
         and_all = '1;
         for (int j = 0; j < 20; j++) begin
            or_all  = or_all | smp[j];
            and_all = and_all & smp[j];
         end
         tog  = or_all & ~and_all;
         etog = exp_gates(s) ^ exp_gates((s + 1) % 6);
         check($countones(and_all) == 1, $sformatf("R4 one held gate s%0d", s), $countones(and_all), 1);
         check($countones(tog) == 2, $sformatf("R4 two toggling gates s%0d", s), $countones(tog), 2);
         check(tog == etog, $sformatf("R9 toggling set s%0d", s), tog, etog);
         check(tog[0] == (s == 1 || s == 5), $sformatf("R9 upper A pwm s%0d", s), tog[0], (s == 1 || s == 5));
      end
   endtask

   task automatic t_boundary;
      int c0 = 0;
      int c3 = 0;
      start_run(0, 0, 40);
      capture(70, 5, 3, 0, 30);
      for (int j = 0; j < 40; j++) if (smp[j] == exp_gates(0)) c0++;
      for (int j = 40; j < 70; j++) if (smp[j] == exp_gates(3)) c3++;
      check(c0 == 40, "R5 old point kept for current period", c0, 40);
      check(c3 == 30, "R5 R6 new point and length next period", c3, 30);
   endtask

   task automatic t_clamp(input int p);
      start_run(0, 128, p);
      capture(4, -1, 0, 0, 0);
      for (int j = 0; j < 4; j++) begin
         logic [5:0] e;
         e = exp_gates(j % 2);
         check(smp[j] == e, $sformatf("R6 clamp p%0d sample %0d", p, j), smp[j], e);
      end
   endtask

   task automatic t_disable;
      start_run(2, 100, 50);
      capture(10, -1, 0, 0, 0);
      @(negedge clk);
      en = 1'b0;
      check(gate != BYP, "R7 still modulating before edge", gate, exp_gates(2));
      @(posedge clk);
      @(negedge clk);
      check(gate == BYP, "R7 bypass one edge after disable", gate, BYP);
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(gate == BYP, "R7 bypass held while disabled", gate, BYP);
   endtask

   task automatic t_bad_sector(input int s);
      int nb = 0;
      start_run(s, 50, 12);
      capture(12, -1, 0, 0, 0);
      for (int j = 0; j < 12; j++) if (smp[j] == BYP) nb++;
      check(nb == 12, $sformatf("R8 invalid sector %0d bypass", s), nb, 12);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_dwell(0, 0, 100);
      t_dwell(0, 128, 100);
      t_dwell(2, 64, 200);
      t_dwell(5, 200, 57);
      t_dwell(3, 255, 1000);
      t_dwell(4, 17, 33);
      t_sector_sweep();
      t_boundary();
      t_clamp(0);
      t_clamp(1);
      t_disable();
      t_bad_sector(6);
      t_bad_sector(7);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule